// File: doc/BRIEF.md
# Quick-Immediate Execute Unit

This unit executes the short-constant instruction class of a 32-bit processor core. Each such instruction is a 16-bit word carrying a small constant: six bits for the arithmetic, logic, shift and test operations, eight bits for the short conditional branch and the base-plus-offset forms. The core's decode stage presents the instruction word with the destination register value, the current N/Z/V/C flags, the instruction address and the already-evaluated branch condition. One clock later the unit returns a register result with its write enable, the new flags with their update strobe, and a branch request with its target. Register storage and condition evaluation stay with the surrounding pipeline.

Each opcode extends its constant in its own way. Add and subtract take the six bits as unsigned. Move, compare, and, and or take them as signed. Bit 5 of the constant picks the shift direction for the logical shift and turns the arithmetic shift into a bit test. The short branch keeps the sign of its byte offset in bit 0.

Instruction word layout: bits 15:12 condition or register field (not used here), bits 11:10 class field (00 selects this class), bits 9:6 opcode, bits 5:0 constant (bits 7:0 for the branch and offset forms).

Top module: `qi_exec`

## Requirements
- R1: After reset, wr_en, flags_we and br_take are 0, and result, flags_out and br_target are 0. The flags are packed as {N,Z,V,C}, with N in bit 3 and C in bit 0.
- R2: Outputs are registered. An instruction sampled with issue_valid high at a rising edge shows its outputs after that edge. In a cycle that follows an edge with issue_valid low, wr_en, flags_we and br_take are 0.
- R3: Move (opcode 8) writes the sign-extended 6-bit constant. It sets N and Z from the result and clears V and C.
- R4: Add (opcode 10) adds the zero-extended constant to rd_val. Subtract (opcode 14) subtracts it from rd_val. C is the carry-out for add and the borrow for subtract. V is signed overflow.
- R5: Compare (opcode 9) computes rd_val minus the sign-extended constant. It sets the flags as subtract does, and wr_en stays 0.
- R6: And (opcode 11) and Or (opcode 15) combine rd_val with the sign-extended constant. N and Z come from the result, and V and C are cleared.
- R7: Logical shift (opcode 13) shifts left when constant bit 5 is 0 and right (zero fill) when bit 5 is 1, by constant bits 4:0.
- R8: Arithmetic shift (opcode 12) with constant bit 5 at 0 shifts rd_val right with sign fill, by bits 4:0.
- R9: Opcode 12 with constant bit 5 at 1 is a bit test of bit k = constant[4:0]. N takes rd_val[k]. Z is 1 when rd_val[k:0] is all zero. V and C are 0, and wr_en stays 0.
- R10: Branch (opcode bits 9:8 = 01) takes offset byte instr[7:0]. When bit 0 is set, the byte is extended with ones above bit 7 and bit 0 is then cleared; otherwise it is zero-extended. br_target = pc + 2 + offset, and br_take = cond_true. A branch writes no register and no flags.
- R11: Base-plus-offset (opcode bits 9:8 = 00) asserts neither wr_en, flags_we nor br_take.
- R12: When flags_we is 0 after an issued quick instruction, flags_out equals the flags_in that were sampled with it.
- R13: An instruction whose class field is not 00 is ignored: no write, no flag update, no branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_valid | input | 1 | Instruction present this cycle |
| instr | input | 16 | Instruction word |
| rd_val | input | 32 | Destination register value |
| pc | input | 32 | Instruction address |
| flags_in | input | 4 | Current flags {N,Z,V,C} |
| cond_true | input | 1 | Evaluated branch condition |
| wr_en | output | 1 | Register write enable |
| result | output | 32 | Register write data |
| flags_we | output | 1 | Flags update strobe |
| flags_out | output | 4 | New flags {N,Z,V,C} |
| br_take | output | 1 | Branch request |
| br_target | output | 32 | Branch target address |

## Verification
Suppose the unit picked the wrong extension rule for a constant. The error would show one cycle after issue as a result that differs in its upper bits, together with a wrong C or N flag. A decoder that put an instruction in the wrong class would show up in the same cycle as a stray wr_en, flags_we or br_take. The directed scenarios check each operation at its edge values: carry and overflow, zero results, the largest shift amounts, both branch offset signs, and the bit-test mask at either end. Because nothing in the unit carries over between instructions, every fault is visible on the cycle right after its instruction.

// File: rtl/qi_pkg.sv
package qi_pkg;
  localparam int XLEN   = 32;
  localparam int IMM_W  = 6;
  localparam int OFF_W  = 8;
  localparam int SHW    = $clog2(XLEN);

  typedef enum logic [3:0] {
    Q_OFFS, Q_BRANCH, Q_MOVE, Q_CMP, Q_ADD, Q_AND,
    Q_ASH, Q_LSH, Q_SUB, Q_OR, Q_NONE
  } qop_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } qflags_t;

  function automatic logic [XLEN-1:0] imm_signed(input logic [IMM_W-1:0] k);
    return {{(XLEN-IMM_W){k[IMM_W-1]}}, k};
  endfunction

  function automatic logic [XLEN-1:0] imm_unsigned(input logic [IMM_W-1:0] k);
    return {{(XLEN-IMM_W){1'b0}}, k};
  endfunction

  function automatic logic [XLEN-1:0] branch_offset(input logic [OFF_W-1:0] b);
    logic [XLEN-1:0] o;
    if (b[0]) o = {{(XLEN-OFF_W){1'b1}}, b[OFF_W-1:1], 1'b0};
    else      o = {{(XLEN-OFF_W){1'b0}}, b};
    return o;
  endfunction

  function automatic logic [XLEN-1:0] low_mask(input logic [SHW-1:0] k);
    return {XLEN{1'b1}} >> (XLEN - 1 - int'(k));
  endfunction
endpackage

// File: rtl/qi_decode.sv
module qi_decode
  import qi_pkg::*;
(
  input  logic [15:0]     instr,
  output qop_e            op,
  output logic [XLEN-1:0] imm_s,
  output logic [XLEN-1:0] imm_u,
  output logic            sel_hi,
  output logic [SHW-1:0]  shamt
);
  logic [3:0] opc;
  assign opc    = instr[9:6];
  assign imm_s  = imm_signed(instr[IMM_W-1:0]);
  assign imm_u  = imm_unsigned(instr[IMM_W-1:0]);
  assign sel_hi = instr[IMM_W-1];
  assign shamt  = instr[SHW-1:0];

  always_comb begin
    if (instr[11:10] != 2'b00) begin
      op = Q_NONE;
    end else begin
      unique casez (opc)
        4'b00??: op = Q_OFFS;
        4'b01??: op = Q_BRANCH;
        4'd8:    op = Q_MOVE;
        4'd9:    op = Q_CMP;
        4'd10:   op = Q_ADD;
        4'd11:   op = Q_AND;
        4'd12:   op = Q_ASH;
        4'd13:   op = Q_LSH;
        4'd14:   op = Q_SUB;
        default: op = Q_OR;
      endcase
    end
  end
endmodule

// File: rtl/qi_alu.sv
module qi_alu
  import qi_pkg::*;
(
  input  qop_e            op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] imm_s,
  input  logic [XLEN-1:0] imm_u,
  input  logic            sel_hi,
  input  logic [SHW-1:0]  shamt,
  input  qflags_t         fin,
  output logic [XLEN-1:0] y,
  output qflags_t         fout,
  output logic            do_wr,
  output logic            do_flags
);
  logic [XLEN:0]   sum_ext;
  logic [XLEN-1:0] sub_b;
  logic [XLEN:0]   diff_ext;
  logic            is_sub_like;
  logic            test_bit;
  logic            test_zero;

  assign sub_b       = (op == Q_CMP) ? imm_s : imm_u;
  assign sum_ext     = {1'b0, a} + {1'b0, imm_u};
  assign diff_ext    = {1'b0, a} - {1'b0, sub_b};
  assign is_sub_like = (op == Q_SUB) || (op == Q_CMP);
  assign test_bit    = a[shamt];
  assign test_zero   = ((a & low_mask(shamt)) == '0);

  always_comb begin
    y        = a;
    fout     = fin;
    do_wr    = 1'b0;
    do_flags = 1'b0;
    case (op)
      Q_MOVE: begin y = imm_s; do_wr = 1'b1; do_flags = 1'b1; end
      Q_ADD:  begin y = sum_ext[XLEN-1:0]; do_wr = 1'b1; do_flags = 1'b1; end
      Q_SUB:  begin y = diff_ext[XLEN-1:0]; do_wr = 1'b1; do_flags = 1'b1; end
      Q_CMP:  begin y = diff_ext[XLEN-1:0]; do_flags = 1'b1; end
      Q_AND:  begin y = a & imm_s; do_wr = 1'b1; do_flags = 1'b1; end
      Q_OR:   begin y = a | imm_s; do_wr = 1'b1; do_flags = 1'b1; end
      Q_LSH: begin
        y = sel_hi ? (a >> shamt) : (a << shamt);
        do_wr = 1'b1; do_flags = 1'b1;
      end
      Q_ASH: begin
        do_flags = 1'b1;
        if (!sel_hi) begin
          y = $signed(a) >>> shamt;
          do_wr = 1'b1;
        end
      end
      default: ;
    endcase

    if (do_flags) begin
      fout.n = y[XLEN-1];
      fout.z = (y == '0);
      fout.v = 1'b0;
      fout.c = 1'b0;
      if (op == Q_ADD) begin
        fout.c = sum_ext[XLEN];
        fout.v = !a[XLEN-1] && y[XLEN-1];
      end else if (is_sub_like) begin
        fout.c = diff_ext[XLEN];
        fout.v = (a[XLEN-1] != sub_b[XLEN-1]) && (y[XLEN-1] != a[XLEN-1]);
      end else if (op == Q_ASH && sel_hi) begin
        fout.n = test_bit;
        fout.z = test_zero;
      end
    end
  end
endmodule

// File: rtl/qi_branch.sv
module qi_branch
  import qi_pkg::*;
(
  input  logic [OFF_W-1:0] off_byte,
  input  logic [XLEN-1:0]  pc,
  output logic [XLEN-1:0]  target
);
  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(2);
  assign target = pc + INSN_BYTES + branch_offset(off_byte);
endmodule

// File: rtl/qi_exec.sv
module qi_exec
  import qi_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_valid,
  input  logic [15:0]     instr,
  input  logic [31:0]     rd_val,
  input  logic [31:0]     pc,
  input  logic [3:0]      flags_in,
  input  logic            cond_true,
  output logic            wr_en,
  output logic [31:0]     result,
  output logic            flags_we,
  output logic [3:0]      flags_out,
  output logic            br_take,
  output logic [31:0]     br_target
);
  qop_e            op;
  logic [XLEN-1:0] imm_s, imm_u, alu_y, tgt;
  logic            sel_hi, alu_wr, alu_fl;
  logic [SHW-1:0]  shamt;
  qflags_t         alu_f;
  logic            is_quick;
  logic            is_branch;

  assign is_quick  = issue_valid && (op != Q_NONE);
  assign is_branch = (op == Q_BRANCH);

  qi_decode u_dec (
    .instr(instr), .op(op), .imm_s(imm_s), .imm_u(imm_u),
    .sel_hi(sel_hi), .shamt(shamt)
  );

  qi_alu u_alu (
    .op(op), .a(rd_val), .imm_s(imm_s), .imm_u(imm_u), .sel_hi(sel_hi),
    .shamt(shamt), .fin(qflags_t'(flags_in)), .y(alu_y), .fout(alu_f),
    .do_wr(alu_wr), .do_flags(alu_fl)
  );

  qi_branch u_br (
    .off_byte(instr[OFF_W-1:0]), .pc(pc), .target(tgt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en     <= 1'b0;
      result    <= '0;
      flags_we  <= 1'b0;
      flags_out <= '0;
      br_take   <= 1'b0;
      br_target <= '0;
    end else begin
      wr_en    <= is_quick && alu_wr;
      flags_we <= is_quick && alu_fl;
      br_take  <= is_quick && is_branch && cond_true;
      if (is_quick) begin
        result    <= alu_y;
        flags_out <= alu_f;
        if (is_branch) br_target <= tgt;
      end
    end
  end
endmodule

// File: rtl/qi_exec_chk.sv
module qi_exec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        issue_valid,
  input logic [15:0] instr,
  input logic        cond_true,
  input logic        is_quick,
  input logic        wr_en,
  input logic [31:0] result,
  input logic        flags_we,
  input logic [3:0]  flags_out,
  input logic        br_take
);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> (!wr_en && !flags_we && !br_take));

  // R5
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && instr[11:6] == 6'b001001) |=> (!wr_en && flags_we));

  // R10
  branch_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && instr[11:8] == 4'b0001) |=> (br_take == $past(cond_true) && !wr_en && !flags_we));

  // R11
  offs_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && instr[11:8] == 4'b0000) |=> (!wr_en && !flags_we && !br_take));

  // R13
  other_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !is_quick) |=> (!wr_en && !flags_we && !br_take));

  // R3
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && flags_we) |-> (flags_out[2] == (result == 32'd0)));

  // R2
  one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en || flags_we, br_take}));
endmodule

bind qi_exec qi_exec_chk u_chk (.*);

// File: tb/qi_exec_bench.sv
module qi_exec_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic [15:0] instr = '0;
  logic [31:0] rd_val = '0;
  logic [31:0] pc = '0;
  logic [3:0]  flags_in = '0;
  logic        cond_true = 1'b0;
  logic        wr_en, flags_we, br_take;
  logic [31:0] result, br_target;
  logic [3:0]  flags_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qi_exec u_qi_exec (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .instr(instr),
    .rd_val(rd_val), .pc(pc), .flags_in(flags_in), .cond_true(cond_true),
    .wr_en(wr_en), .result(result), .flags_we(flags_we), .flags_out(flags_out),
    .br_take(br_take), .br_target(br_target)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [15:0] qword(input logic [3:0] opc, input logic [5:0] k);
    return {4'h0, 2'b00, opc, k};
  endfunction

  task automatic issue(input logic [15:0] w, input logic [31:0] a, input logic [3:0] f,
                       input logic [31:0] p, input logic c);
    @(negedge clk);
    instr = w; rd_val = a; flags_in = f; pc = p; cond_true = c; issue_valid = 1'b1;
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  task automatic expect_alu(input string req, input logic exp_wr, input logic [31:0] exp_y,
                            input logic [3:0] exp_f);
    chk(req, "wr_en", 32'(wr_en), 32'(exp_wr));
    if (exp_wr) chk(req, "result", result, exp_y);
    chk(req, "flags_we", 32'(flags_we), 32'd1);
    chk(req, "flags", 32'(flags_out), 32'(exp_f));
    chk(req, "br_take", 32'(br_take), 32'd0);
  endtask

  task automatic t_reset();
    chk("R1", "wr_en", 32'(wr_en), 0);
    chk("R1", "flags_we", 32'(flags_we), 0);
    chk("R1", "br_take", 32'(br_take), 0);
    chk("R1", "result", result, 0);
    chk("R1", "flags", 32'(flags_out), 0);
    chk("R1", "target", br_target, 0);
  endtask

  task automatic t_move();
    issue(qword(4'd8, 6'h3F), 32'h1234, 4'b0011, 0, 0);
    expect_alu("R3", 1, 32'hFFFF_FFFF, 4'b1000);
    issue(qword(4'd8, 6'h00), 32'h1234, 4'b1111, 0, 0);
    expect_alu("R3", 1, 32'h0, 4'b0100);
  endtask

  task automatic t_addsub();
    issue(qword(4'd10, 6'h3F), 32'hFFFF_FFF0, 0, 0, 0);
    expect_alu("R4", 1, 32'h0000_002F, 4'b0001);
    issue(qword(4'd10, 6'h01), 32'h7FFF_FFFF, 0, 0, 0);
    expect_alu("R4", 1, 32'h8000_0000, 4'b1010);
    issue(qword(4'd14, 6'h05), 32'h5, 0, 0, 0);
    expect_alu("R4", 1, 32'h0, 4'b0100);
    issue(qword(4'd14, 6'h01), 32'h0, 0, 0, 0);
    expect_alu("R4", 1, 32'hFFFF_FFFF, 4'b1001);
    issue(qword(4'd14, 6'h3F), 32'h10, 0, 0, 0);
    expect_alu("R4", 1, 32'hFFFF_FFD1, 4'b1001);
  endtask

  task automatic t_cmp();
    issue(qword(4'd9, 6'h3F), 32'hFFFF_FFFF, 4'b0000, 0, 0);
    expect_alu("R5", 0, 0, 4'b0100);
    issue(qword(4'd9, 6'h01), 32'h8000_0000, 4'b0000, 0, 0);
    expect_alu("R5", 0, 0, 4'b0010);
  endtask

  task automatic t_logic();
    issue(qword(4'd11, 6'h3E), 32'h13, 0, 0, 0);
    expect_alu("R6", 1, 32'h12, 4'b0000);
    issue(qword(4'd15, 6'h20), 32'h5, 4'b0011, 0, 0);
    expect_alu("R6", 1, 32'hFFFF_FFE5, 4'b1000);
    issue(qword(4'd11, 6'h00), 32'hFFFF_FFFF, 0, 0, 0);
    expect_alu("R6", 1, 32'h0, 4'b0100);
  endtask

  task automatic t_shift();
    issue(qword(4'd13, 6'h04), 32'h1, 0, 0, 0);
    expect_alu("R7", 1, 32'h10, 4'b0000);
    issue(qword(4'd13, 6'h24), 32'h80, 0, 0, 0);
    expect_alu("R7", 1, 32'h8, 4'b0000);
    issue(qword(4'd13, 6'h3F), 32'h8000_0000, 0, 0, 0);
    expect_alu("R7", 1, 32'h1, 4'b0000);
    issue(qword(4'd12, 6'h04), 32'h8000_0000, 0, 0, 0);
    expect_alu("R8", 1, 32'hF800_0000, 4'b1000);
    issue(qword(4'd12, 6'h1F), 32'h4000_0000, 0, 0, 0);
    expect_alu("R8", 1, 32'h0, 4'b0100);
  endtask

  task automatic t_btst();
    issue(qword(4'd12, 6'h23), 32'h8, 4'b0011, 0, 0);
    expect_alu("R9", 0, 0, 4'b1000);
    issue(qword(4'd12, 6'h23), 32'h4, 0, 0, 0);
    expect_alu("R9", 0, 0, 4'b0000);
    issue(qword(4'd12, 6'h23), 32'hFFFF_FFF0, 0, 0, 0);
    expect_alu("R9", 0, 0, 4'b0100);
    issue(qword(4'd12, 6'h3F), 32'h7FFF_FFFF, 0, 0, 0);
    expect_alu("R9", 0, 0, 4'b0000);
  endtask

  task automatic t_branch();
    issue({4'h0, 4'b0001, 8'h10}, 0, 4'b0101, 32'h100, 1);
    chk("R10", "take", 32'(br_take), 1);
    chk("R10", "target", br_target, 32'h112);
    chk("R10", "wr_en", 32'(wr_en), 0);
    chk("R12", "flags kept", 32'(flags_out), 32'h5);
    issue({4'h0, 4'b0001, 8'h11}, 0, 0, 32'h100, 1);
    chk("R10", "target neg", br_target, 32'h12);
    issue({4'h0, 4'b0001, 8'hFF}, 0, 0, 32'h1000, 0);
    chk("R10", "no take", 32'(br_take), 0);
    chk("R10", "target -2", br_target, 32'h1000);
  endtask

  task automatic t_offs();
    issue({4'h3, 4'b0000, 8'h7C}, 32'h40, 4'b1010, 0, 1);
    chk("R11", "wr_en", 32'(wr_en), 0);
    chk("R11", "flags_we", 32'(flags_we), 0);
    chk("R11", "br_take", 32'(br_take), 0);
    chk("R12", "flags kept", 32'(flags_out), 32'hA);
  endtask

  task automatic t_other();
    issue({4'h0, 2'b01, 4'd8, 6'h3F}, 32'h0, 0, 0, 1);
    chk("R13", "wr_en", 32'(wr_en), 0);
    chk("R13", "flags_we", 32'(flags_we), 0);
    chk("R13", "br_take", 32'(br_take), 0);
    @(negedge clk);
    chk("R2", "idle wr_en", 32'(wr_en), 0);
    chk("R2", "idle flags_we", 32'(flags_we), 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_move();
    t_addsub();
    t_cmp();
    t_logic();
    t_shift();
    t_btst();
    t_branch();
    t_offs();
    t_other();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule